// File: doc/BRIEF.md
# Seconds Counter with Deferred Set-Time and Alarm

This block keeps an unsigned 32-bit count of elapsed seconds. A separate prescaler supplies a single-cycle strobe once per second and a live sub-second tick count. Software reaches the block through a small memory-mapped register window. It can write a new time, read that value back, read the running count, read the live sub-second tick, and program an alarm. The calendar conversion happens in software.

A new time does not take effect when it is written. The value is held as pending and is copied into the running count at the next one-second strobe. Until then, the running count keeps its old value and the readback register shows the written value.

The block drives a two-bit event vector to the interrupt block. Bit 0 pulses on every second boundary. Bit 1 pulses when a boundary moves the count onto the programmed alarm value.

Top module: `sectime_core`

## Requirements
- R1: After reset, the current-time register (offset 0x10) reads 0, the set-time readback register (0x04) reads 0, the alarm register (0x18) reads 0, and both event bits are 0.
- R2: A write to the set-time register (0x00) leaves the current time (0x10) unchanged until the next one-second strobe.
- R3: At a strobe with a set-time write pending, the current time becomes the written value with no increment, and the pending state clears. Later strobes increment from that value.
- R4: The readback register (0x04) returns the last value written to 0x00, both before and after that value is loaded.
- R5: At a strobe with no write pending, the current time increases by 1, wrapping from 0xFFFFFFFF to 0.
- R6: Event bit 0 is high for exactly the one cycle after each strobe edge, which is the cycle in which the new count is first visible.
- R7: Event bit 1 is high for one cycle, aligned with bit 0, when a strobe changes the count to a value equal to the alarm register.
- R8: An alarm value of 0 never raises event bit 1, even when the count wraps to 0.
- R9: Event bit 1 does not fire again while the count and the alarm stay equal, including when a strobe loads a pending value equal to the present count.
- R10: Offset 0x14 reads the prescaler's sub-second tick live, zero-extended into the low 16 bits.
- R11: The alarm register (0x18) reads back its written value. Writes to 0x04, 0x10 and 0x14 change no state. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sec_tick | input | 1 | One-second strobe from the prescaler, one cycle wide |
| sub_tick | input | 16 | Live sub-second tick count from the prescaler |
| evt | output | 2 | Event pulses: bit 0 second boundary, bit 1 alarm match |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a 16-bit sub-tick and an 8-bit offset. Because a pending value is loaded at a strobe, the count can be placed just below 0xFFFFFFFF. This brings the wrap to 0, and the rule that a zero alarm stays silent, within three strobes. The same mechanism places the count two steps before an alarm. It also reloads a value equal to the alarm, which shows the match firing once and not again.

// File: rtl/sectime_pkg.sv
// Shared constants for the seconds counter: register offsets and event bit positions.
// Assumes byte offsets that fit in 8 bits.
package sectime_pkg;
    localparam logic [7:0] OFS_SET_WR = 8'h00;
    localparam logic [7:0] OFS_SET_RB = 8'h04;
    localparam logic [7:0] OFS_NOW    = 8'h10;
    localparam logic [7:0] OFS_SUB    = 8'h14;
    localparam logic [7:0] OFS_ALM    = 8'h18;
    localparam int EVT_SEC = 0;
    localparam int EVT_ALM = 1;
    localparam int EVT_N   = 2;
endpackage

// File: rtl/sectime_regs.sv
// Register window: holds the set-time value and the alarm value, and decodes writes and reads.
// Assumes TW >= SW and that reads are combinational from the address.
module sectime_regs
    import sectime_pkg::*;
#(
    parameter int AW = 8,
    parameter int TW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [TW-1:0] bus_wdata,
    input  logic [TW-1:0] cur,
    input  logic [SW-1:0] sub_tick,
    output logic          set_stb,
    output logic [TW-1:0] set_val,
    output logic [TW-1:0] alarm_q,
    output logic [TW-1:0] bus_rdata
);
    logic hit_set, hit_alm;

    // Decode the writable offsets.
    always_comb begin
        hit_set = (bus_addr == AW'(OFS_SET_WR));
        hit_alm = (bus_addr == AW'(OFS_ALM));
        set_stb = bus_wr && hit_set;
    end

    // Capture the set-time value; it stays readable after the load.
    always_ff @(posedge clk) begin
        if (!rst_n)       set_val <= '0;
        else if (set_stb) set_val <= bus_wdata;
    end

    // Capture the alarm value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 alarm_q <= '0;
        else if (bus_wr && hit_alm) alarm_q <= bus_wdata;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_SET_RB))   bus_rdata = set_val;
        else if (bus_addr == AW'(OFS_NOW)) bus_rdata = cur;
        else if (bus_addr == AW'(OFS_SUB)) bus_rdata = TW'(sub_tick);
        else if (hit_alm)                  bus_rdata = alarm_q;
    end

    // R11: no writable register moves unless its own offset is written.
    p_alarm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit_alm) |=> $stable(alarm_q));
    // R4: the readback value changes only through a set-time write.
    p_rb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !set_stb |=> $stable(set_val));
endmodule

// File: rtl/sectime_count.sv
// Seconds count: loads a pending set-time value at a strobe, otherwise increments.
// Assumes sec_tick is a one-cycle strobe. A write that coincides with a strobe stays pending.
module sectime_count #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          set_stb,
    input  logic [TW-1:0] set_val,
    output logic [TW-1:0] cur,
    output logic [TW-1:0] cur_nxt
);
    logic pend;

    // Value the count takes at the coming strobe.
    always_comb cur_nxt = pend ? set_val : cur + TW'(1);

    // Pending flag: set by a write, cleared by the strobe that consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (set_stb)  pend <= 1'b1;
        else if (sec_tick) pend <= 1'b0;
    end

    // Running count advances only at a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur <= '0;
        else if (sec_tick) cur <= cur_nxt;
    end

    // R2: the count holds between strobes.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(cur));
    // R3: a pending value is loaded without an increment.
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && pend) |=> (cur == $past(set_val)));
    // R5: without a pending value, the count steps by one.
    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !pend) |=> (cur == $past(cur) + TW'(1)));
endmodule

// File: rtl/sectime_alarm.sv
// Event generator: second-boundary pulse and alarm-match pulse, both registered.
// Assumes cur_nxt is the value cur takes at the same strobe edge.
module sectime_alarm
    import sectime_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [TW-1:0]    cur,
    input  logic [TW-1:0]    cur_nxt,
    input  logic [TW-1:0]    alarm_q,
    output logic [EVT_N-1:0] evt
);
    logic hit;

    // Match only when the strobe moves the count onto a nonzero alarm.
    always_comb hit = (cur_nxt == alarm_q) && (alarm_q != '0) && (cur_nxt != cur);

    // Register both events so they align with the new count.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= '0;
        else begin
            evt[EVT_SEC] <= sec_tick;
            evt[EVT_ALM] <= sec_tick && hit;
        end
    end

    // R6: one pulse per strobe.
    p_sec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> evt[EVT_SEC]);
    p_sec_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> !evt[EVT_SEC]);
    // R7: an alarm pulse comes with a second pulse and a matching count.
    p_alm_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EVT_ALM] |-> (evt[EVT_SEC] && cur == $past(alarm_q)));
    // R8: a zero alarm never fires.
    p_alm_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EVT_ALM] |-> ($past(alarm_q) != '0));
    // R9: the count changed into the match.
    p_alm_changed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EVT_ALM] |-> (cur != $past(cur)));
endmodule

// File: rtl/sectime_core.sv
// Top of the seconds counter: register window, count with deferred load, event generation.
// Assumes a one-cycle sec_tick from an external prescaler. Events go to an interrupt block.
module sectime_core
    import sectime_pkg::*;
#(
    parameter int AW = 8,
    parameter int TW = 32,
    parameter int SW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [TW-1:0]    bus_wdata,
    output logic [TW-1:0]    bus_rdata,
    input  logic             sec_tick,
    input  logic [SW-1:0]    sub_tick,
    output logic [EVT_N-1:0] evt
);
    logic          set_stb;
    logic [TW-1:0] set_val, alarm_q, cur, cur_nxt;

    sectime_regs #(.AW(AW), .TW(TW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cur(cur), .sub_tick(sub_tick),
        .set_stb(set_stb), .set_val(set_val), .alarm_q(alarm_q),
        .bus_rdata(bus_rdata)
    );

    sectime_count #(.TW(TW)) u_count (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_stb(set_stb),
        .set_val(set_val), .cur(cur), .cur_nxt(cur_nxt)
    );

    sectime_alarm #(.TW(TW)) u_alarm (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur(cur),
        .cur_nxt(cur_nxt), .alarm_q(alarm_q), .evt(evt)
    );
endmodule

// File: tb/sim_sectime_core.sv
module sim_sectime_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_tick = 1'b0;
    logic [15:0] sub_tick = '0;
    logic [1:0]  evt;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sectime_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
        .sub_tick(sub_tick), .evt(evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // One strobe; returns at the negedge where the new count and events are visible.
    task automatic strobe();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h10, d); chk("R1 now", d, 0);
        rd(8'h04, d); chk("R1 readback", d, 0);
        rd(8'h18, d); chk("R1 alarm", d, 0);
        chk("R1 evt", {30'd0, evt}, 0);
    endtask

    task automatic t_incr();
        logic [31:0] d;
        strobe();
        chk("R6 sec evt", {31'd0, evt[0]}, 1);
        rd(8'h10, d); chk("R5 increment", d, 1);
        chk("R6 pulse ends", {31'd0, evt[0]}, 0);
    endtask

    task automatic t_set_load();
        logic [31:0] d;
        wr(8'h00, 32'd1000);
        rd(8'h10, d); chk("R2 not yet loaded", d, 1);
        rd(8'h04, d); chk("R4 readback pending", d, 1000);
        strobe();
        rd(8'h10, d); chk("R3 loaded", d, 1000);
        strobe();
        rd(8'h10, d); chk("R3 increments after load", d, 1001);
        rd(8'h04, d); chk("R4 readback kept", d, 1000);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(8'h18, 32'd0);
        wr(8'h00, 32'hFFFF_FFFE);
        strobe();
        strobe();
        rd(8'h10, d); chk("R5 top", d, 32'hFFFF_FFFF);
        strobe();
        chk("R8 no alarm at zero", {31'd0, evt[1]}, 0);
        rd(8'h10, d); chk("R5 wrap", d, 0);
    endtask

    task automatic t_alarm();
        logic [31:0] d;
        wr(8'h18, 32'd2005);
        rd(8'h18, d); chk("R11 alarm readback", d, 2005);
        wr(8'h00, 32'd2003);
        strobe(); chk("R7 no early alarm", {31'd0, evt[1]}, 0);
        strobe(); chk("R7 no early alarm", {31'd0, evt[1]}, 0);
        strobe();
        chk("R7 alarm fires", {30'd0, evt}, 3);
        @(negedge clk);
        chk("R7 alarm single cycle", {31'd0, evt[1]}, 0);
        wr(8'h00, 32'd2005);
        strobe();
        chk("R9 no repeat on equal load", {31'd0, evt[1]}, 0);
        rd(8'h10, d); chk("R9 count", d, 2005);
        strobe();
        chk("R9 no alarm after match", {31'd0, evt[1]}, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] d, base;
        rd(8'h10, base);
        wr(8'h10, 32'h0000_DEAD);
        wr(8'h04, 32'h0000_BEEF);
        wr(8'h14, 32'd1);
        rd(8'h10, d); chk("R11 now not writable", d, base);
        rd(8'h04, d); chk("R11 readback not writable", d, 2005);
        strobe();
        rd(8'h10, d); chk("R11 no pending from other offsets", d, base + 1);
        rd(8'h08, d); chk("R11 unmapped", d, 0);
    endtask

    task automatic t_sub();
        logic [31:0] d;
        sub_tick = 16'hABCD;
        rd(8'h14, d); chk("R10 sub tick", d, 32'h0000_ABCD);
        sub_tick = 16'h1234;
        rd(8'h14, d); chk("R10 sub tick live", d, 32'h0000_1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_incr();
        t_set_load();
        t_wrap();
        t_alarm();
        t_ignored();
        t_sub();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule